// File: doc/BRIEF.md
# Two-Step Converter Bus Controller

This block is the digital sequencer behind a four-input, 8-bit two-step converter. To a microprocessor the converter looks like a single memory location or I/O port. The block takes a chip select, read and write strobes, two channel-address bits and two static strap inputs. One strap picks the bus protocol and the other picks true sample/hold or track/hold acquisition. It latches and decodes the channel address and runs the acquisition phase, then the upper-nibble decision phase, then the lower-nibble decision phase. It then raises an end-of-conversion interrupt and drives the result onto the data bus.

The comparator banks are outside the block. Each stage's 4-bit decision arrives as a digital code and is sampled at the end of its phase. Each asynchronous strobe passes through a two-flop synchronizer and a previous-value register before its edges are used. A strobe change therefore takes effect on the third rising clock edge after it appears. Every internal delay is a count of system-clock cycles.

The pin that is a write input in one protocol is an open-drain ready output in the other. It is modelled as the input `wr_ni` plus the pull-down enable `rdy_low_o`. The tri-state bus is modelled as `data_o` plus the drive enable `data_oe_o`, and `data_o` reads zero whenever it is not driven.

Top module: `tsadc_bus_ctrl`

## Requirements
- R1: With `mode_wr_i`=0, `rdy_low_o` is 1 while the synchronized chip select is low and no result is pending, and it releases to 0 when a conversion completes. With `mode_wr_i`=1, `rdy_low_o` is always 0.
- R2: `chan_sel_o` is one-hot, and bit {A1,A0} is set. 00 is input 1 (bit 0), A0=1/A1=0 is input 2 (bit 1), A0=0/A1=1 is input 3 (bit 2), and 11 is input 4 (bit 3).
- R3: Which edge latches the address depends on both straps. With `mode_sh_i`=1, the chip-select falling edge latches it in either protocol. With `mode_sh_i`=0, the starting strobe's falling edge latches it while chip select is low: the read strobe when `mode_wr_i`=0, the write strobe when `mode_wr_i`=1. Address changes at other times have no effect.
- R4: In read-only protocol, a read falling edge with chip select low starts a conversion. The upper code is sampled ACQ_CYC cycles later. The interrupt (`int_no` low) follows LSB_CYC cycles after that. A read or chip-select rising edge clears the interrupt. If that rising edge comes before completion, the conversion is abandoned and no interrupt follows.
- R5: In write-then-read protocol, a write falling edge with chip select low starts a conversion. The upper code is sampled at the write rising edge, and the interrupt follows LSB_CYC cycles later. The bus is driven only while the interrupt is pending and both read and chip select are low.
- R6: In write-then-read protocol, a read falling edge during the lower-nibble phase completes the conversion on that edge. Until then the bus stays undriven.
- R7: With chip select and read held low, the result drives the bus as soon as it completes. A write rising edge clears the interrupt, and a write falling edge alone does not.
- R8: With `mode_sh_i`=1, a conversion start that arrives within GAP_CYC cycles of completion is ignored.
- R9: After reset, for POR_CYC cycles chip select is ignored, `int_no` stays 1, `rdy_low_o` stays 0 and the bus is undriven.
- R10: The result word is the upper-stage code in bits 7:4 and the lower-stage code in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low (write-then-read protocol) |
| addr_i | input | 2 | Channel address {A1,A0} |
| mode_wr_i | input | 1 | Protocol strap: 0 read-only, 1 write-then-read |
| mode_sh_i | input | 1 | Acquisition strap: 0 track/hold, 1 sample/hold |
| msb_code_i | input | 4 | Upper-stage comparator code |
| lsb_code_i | input | 4 | Lower-stage comparator code |
| int_no | output | 1 | End-of-conversion interrupt, active low |
| rdy_low_o | output | 1 | Open-drain ready pull-down enable (read-only protocol) |
| data_o | output | 8 | Result word, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| chan_sel_o | output | 4 | One-hot selected analog input |

## Verification
The bench builds the block with ACQ_CYC=4, LSB_CYC=5, GAP_CYC=6 and POR_CYC=20. With these values the whole power-up window, an abandoned read, the early read inside the five-cycle lower phase, and a start blocked by the six-cycle sample/hold gap each fit in a few dozen cycles. Because the gap is longer than the three-cycle synchronizer latency, a write pulse issued right after the interrupt lands inside the blocked window. A cycle model of the requirements runs beside the design and is compared on every clock.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
  localparam int NCH = 4;
  localparam int AW  = $clog2(NCH);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSB  = 2'd1,
    ST_LSB  = 2'd2
  } conv_st_e;
endpackage

// File: rtl/tsadc_sync.sv
module tsadc_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tsadc_chan_latch.sv
module tsadc_chan_latch
  import tsadc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          mode_wr_i,
  input  logic          mode_sh_i,
  input  logic          cs_act_i,
  input  logic          cs_fall_i,
  input  logic          rd_fall_i,
  input  logic          wr_fall_i,
  input  logic [AW-1:0] addr_i,
  output logic [NCH-1:0] chan_sel_o
);
  logic [AW-1:0] addr_q;
  logic          lat;

  // sample/hold latches on select; track/hold on the starting strobe
  assign lat = en_i & (mode_sh_i ? cs_fall_i
                                 : (cs_act_i & (mode_wr_i ? wr_fall_i : rd_fall_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_q <= '0;
    else if (lat) addr_q <= addr_i;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign chan_sel_o[g] = (addr_q == AW'(g));
  end

  AST_CHAN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_sel_o) == 1); // R2
  AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat |=> $stable(chan_sel_o)); // R3
endmodule

// File: rtl/tsadc_seq.sv
module tsadc_seq
  import tsadc_pkg::*;
#(
  parameter int ACQ_CYC = 8,
  parameter int LSB_CYC = 6,
  parameter int GAP_CYC = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       mode_wr_i,
  input  logic       mode_sh_i,
  input  logic       cs_act_i,
  input  logic       cs_rise_i,
  input  logic       rd_fall_i,
  input  logic       rd_rise_i,
  input  logic       wr_fall_i,
  input  logic       wr_rise_i,
  input  logic [3:0] msb_code_i,
  input  logic [3:0] lsb_code_i,
  output logic       int_o,
  output logic [7:0] result_o
);
  localparam int CMAX = (ACQ_CYC > LSB_CYC) ? ACQ_CYC : LSB_CYC;
  localparam int CW   = $clog2(CMAX) + 1;
  localparam int GW   = $clog2(GAP_CYC + 1);

  conv_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gap_q;
  logic [3:0]    msb_q;
  logic [7:0]    res_q;
  logic          int_q;
  logic          go, clr, abort, early;

  assign go    = cs_act_i & (mode_wr_i ? wr_fall_i : rd_fall_i);
  assign abort = rd_rise_i | cs_rise_i;
  assign clr   = abort | (mode_wr_i & wr_rise_i);
  assign early = mode_wr_i & rd_fall_i & cs_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      gap_q <= '0;
      msb_q <= '0;
      res_q <= '0;
      int_q <= 1'b0;
    end else if (!en_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      gap_q <= '0;
      int_q <= 1'b0;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (clr)         int_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go && gap_q == '0) begin
            st_q  <= ST_MSB;
            cnt_q <= CW'(ACQ_CYC - 1);
          end
        end
        ST_MSB: begin
          if (!mode_wr_i) begin
            if (abort) st_q <= ST_IDLE;
            else if (cnt_q == '0) begin
              msb_q <= msb_code_i;
              st_q  <= ST_LSB;
              cnt_q <= CW'(LSB_CYC - 1);
            end else cnt_q <= cnt_q - 1'b1;
          end else if (wr_rise_i) begin
            msb_q <= msb_code_i;
            st_q  <= ST_LSB;
            cnt_q <= CW'(LSB_CYC - 1);
          end
        end
        ST_LSB: begin
          if (!mode_wr_i && abort) st_q <= ST_IDLE;
          else if (cnt_q == '0 || early) begin
            res_q <= {msb_q, lsb_code_i};
            int_q <= 1'b1;
            st_q  <= ST_IDLE;
            if (mode_sh_i) gap_q <= GW'(GAP_CYC);
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign int_o    = int_q;
  assign result_o = res_q;

  AST_GAP_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && gap_q != '0) |=> st_q == ST_IDLE); // R8
  AST_LSB_FROM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LSB && $past(st_q) != ST_LSB) |-> $past(st_q) == ST_MSB); // R4
  AST_WR_MSB_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_wr_i && st_q == ST_MSB && !wr_rise_i) |=> st_q == ST_MSB); // R5
endmodule

// File: rtl/tsadc_bus_ctrl.sv
module tsadc_bus_ctrl
  import tsadc_pkg::*;
#(
  parameter int ACQ_CYC = 8,
  parameter int LSB_CYC = 6,
  parameter int GAP_CYC = 15,
  parameter int POR_CYC = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] addr_i,
  input  logic       mode_wr_i,
  input  logic       mode_sh_i,
  input  logic [3:0] msb_code_i,
  input  logic [3:0] lsb_code_i,
  output logic       int_no,
  output logic       rdy_low_o,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic [3:0] chan_sel_o
);
  localparam int PW = $clog2(POR_CYC + 1);

  logic [2:0]    strb_s, strb_p;  // {cs, rd, wr}, active low
  logic [AW-1:0] addr_s;
  logic [PW-1:0] por_q;
  logic          en;
  logic          cs_fall, cs_rise, rd_fall, rd_rise, wr_fall, wr_rise, cs_act;
  logic          int_q;
  logic [7:0]    result;

  tsadc_sync #(.W(3), .RST_VAL(3'b111)) u_sync_strb (
    .clk_i, .rst_ni, .d_i({cs_ni, rd_ni, wr_ni}), .q_o(strb_s)
  );
  tsadc_sync #(.W(AW), .RST_VAL('0)) u_sync_addr (
    .clk_i, .rst_ni, .d_i(addr_i), .q_o(addr_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_p <= 3'b111;
      por_q  <= '0;
    end else begin
      strb_p <= strb_s;
      if (por_q != PW'(POR_CYC)) por_q <= por_q + 1'b1;
    end
  end

  assign en      = (por_q == PW'(POR_CYC));
  assign cs_fall =  strb_p[2] & ~strb_s[2];
  assign cs_rise = ~strb_p[2] &  strb_s[2];
  assign rd_fall =  strb_p[1] & ~strb_s[1];
  assign rd_rise = ~strb_p[1] &  strb_s[1];
  assign wr_fall =  strb_p[0] & ~strb_s[0];
  assign wr_rise = ~strb_p[0] &  strb_s[0];
  assign cs_act  = ~strb_s[2];

  tsadc_chan_latch u_chan (
    .clk_i, .rst_ni, .en_i(en), .mode_wr_i, .mode_sh_i,
    .cs_act_i(cs_act), .cs_fall_i(cs_fall), .rd_fall_i(rd_fall), .wr_fall_i(wr_fall),
    .addr_i(addr_s), .chan_sel_o
  );

  tsadc_seq #(.ACQ_CYC(ACQ_CYC), .LSB_CYC(LSB_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk_i, .rst_ni, .en_i(en), .mode_wr_i, .mode_sh_i,
    .cs_act_i(cs_act), .cs_rise_i(cs_rise), .rd_fall_i(rd_fall), .rd_rise_i(rd_rise),
    .wr_fall_i(wr_fall), .wr_rise_i(wr_rise),
    .msb_code_i, .lsb_code_i, .int_o(int_q), .result_o(result)
  );

  assign int_no    = ~int_q;
  assign data_oe_o = en & int_q & ~strb_s[1] & cs_act;
  assign data_o    = data_oe_o ? result : 8'h00;
  assign rdy_low_o = en & ~mode_wr_i & cs_act & ~int_q;

  AST_RDY_QUIET_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |-> !rdy_low_o); // R1
  AST_OE_NEEDS_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !int_no); // R5
  AST_POR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (int_no && !data_oe_o && !rdy_low_o)); // R9
  AST_BUS_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == 8'h00); // R10
endmodule

// File: tb/tsadc_bus_ctrl_tb.sv
module tsadc_bus_ctrl_tb;
  localparam int P_ACQ = 4, P_LSB = 5, P_GAP = 6, P_POR = 20;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, mode_wr = 0, mode_sh = 0;
  logic [1:0] addr = 0;
  logic [3:0] msb = 0, lsb = 0;
  logic int_no, rdy_low, data_oe;
  logic [7:0] data;
  logic [3:0] chan;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  tsadc_bus_ctrl #(.ACQ_CYC(P_ACQ), .LSB_CYC(P_LSB), .GAP_CYC(P_GAP), .POR_CYC(P_POR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n), .addr_i(addr),
    .mode_wr_i(mode_wr), .mode_sh_i(mode_sh), .msb_code_i(msb), .lsb_code_i(lsb),
    .int_no(int_no), .rdy_low_o(rdy_low), .data_o(data), .data_oe_o(data_oe), .chan_sel_o(chan)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 2-flop sync + previous value, then phase model
  bit [2:0] ms1, ms2, mp;
  bit [1:0] ma1, ma2;
  int m_por, m_st, m_cnt, m_gap, m_addr;
  bit m_int;
  bit [3:0] m_msb;
  bit [7:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 3'b111; ms2 = 3'b111; mp = 3'b111; ma1 = 0; ma2 = 0;
      m_por = 0; m_st = 0; m_cnt = 0; m_gap = 0; m_int = 0; m_addr = 0;
      m_msb = 0; m_res = 0;
    end else begin
      bit en, csf, csr, rdf, rdr, wrf, wrr, csa, start;
      int g0;
      en  = (m_por == P_POR);
      csf = mp[2] && !ms2[2]; csr = !mp[2] && ms2[2];
      rdf = mp[1] && !ms2[1]; rdr = !mp[1] && ms2[1];
      wrf = mp[0] && !ms2[0]; wrr = !mp[0] && ms2[0];
      csa = !ms2[2];
      if (en) begin
        if (mode_sh ? csf : (csa && (mode_wr ? wrf : rdf))) m_addr = ma2;
        g0 = m_gap;
        if (m_gap > 0) m_gap--;
        if (rdr || csr || (mode_wr && wrr)) m_int = 0;
        start = csa && (mode_wr ? wrf : rdf);
        if (m_st == 0) begin
          if (start && g0 == 0) begin m_st = 1; m_cnt = P_ACQ - 1; end
        end else if (m_st == 1) begin
          if (!mode_wr) begin
            if (rdr || csr) m_st = 0;
            else if (m_cnt == 0) begin m_msb = msb; m_st = 2; m_cnt = P_LSB - 1; end
            else m_cnt--;
          end else if (wrr) begin m_msb = msb; m_st = 2; m_cnt = P_LSB - 1; end
        end else begin
          if (!mode_wr && (rdr || csr)) m_st = 0;
          else if (m_cnt == 0 || (mode_wr && rdf && csa)) begin
            m_res = {m_msb, lsb}; m_int = 1; m_st = 0;
            if (mode_sh) m_gap = P_GAP;
          end else m_cnt--;
        end
      end else begin
        m_st = 0; m_cnt = 0; m_gap = 0; m_int = 0;
      end
      if (m_por != P_POR) m_por++;
      mp = ms2; ms2 = ms1; ms1 = {cs_n, rd_n, wr_n};
      ma2 = ma1; ma1 = addr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit en, oe;
      en = (m_por == P_POR);
      oe = en && m_int && !ms2[1] && !ms2[2];
      chk("R4 int per-cycle", int_no, !m_int);
      chk("R5 bus enable per-cycle", data_oe, oe);
      chk("R10 data per-cycle", data, oe ? m_res : 0);
      chk("R1 ready per-cycle", rdy_low, en && !mode_wr && !ms2[2] && !m_int);
      chk("R2 channel per-cycle", chan, 4'b1 << m_addr);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_int(input int lim);
    int k = 0;
    while (int_no && k < lim) begin tick(1); k++; end
  endtask

  task automatic restart(input bit w, input bit s);
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; mode_wr = w; mode_sh = s;
    tick(2); rst_n = 1; tick(P_POR + 4);
  endtask

  initial begin
    tick(2);
    chk("R9 int high in reset", int_no, 1);
    rst_n = 1;
    // R9: select ignored while power-up window runs
    cs_n = 0; tick(5);
    chk("R9 int high during power-up", int_no, 1);
    chk("R9 ready ignores select", rdy_low, 0);
    chk("R9 bus undriven", data_oe, 0);
    tick(P_POR);
    chk("R1 ready low with select, read-only", rdy_low, 1);

    // read-only, track/hold
    addr = 2'b10; msb = 4'hA; lsb = 4'h5; rd_n = 0;
    wait_int(60);
    chk("R4 interrupt after read start", int_no, 0);
    chk("R10 word order", data, 8'hA5);
    chk("R1 ready released at end", rdy_low, 0);
    chk("R2 input 3 selected", chan, 4'b0100);
    rd_n = 1; tick(4);
    chk("R4 read rise clears int", int_no, 1);
    chk("R4 read rise releases bus", data_oe, 0);
    addr = 2'b01; rd_n = 0; tick(4); rd_n = 1; tick(15);
    chk("R4 abandoned conversion no int", int_no, 1);
    chk("R3 read edge latches address", chan, 4'b0010);
    cs_n = 1; tick(4);

    // write-then-read, track/hold
    restart(1, 0);
    cs_n = 0; tick(4);
    chk("R1 ready idle in write protocol", rdy_low, 0);
    addr = 2'b11; wr_n = 0; tick(2); addr = 2'b00; tick(3);
    msb = 4'h3; lsb = 4'hC; wr_n = 1;
    wait_int(40);
    chk("R5 interrupt after write", int_no, 0);
    chk("R5 bus undriven while read high", data_oe, 0);
    chk("R3 write edge latched address", chan, 4'b1000);
    rd_n = 0; tick(4);
    chk("R5 data on read", data, 8'h3C);
    rd_n = 1; tick(4);
    chk("R5 read rise clears int", int_no, 1);

    // early completion by read inside lower phase
    msb = 4'h7; lsb = 4'h1; wr_n = 0; tick(3); wr_n = 1; tick(1);
    rd_n = 0; tick(2);
    chk("R6 bus undriven before int", data_oe, 0);
    tick(1);
    chk("R6 early interrupt", int_no, 0);
    chk("R6 early data", data, 8'h71);
    rd_n = 1; tick(4);

    // stand-alone
    rd_n = 0; msb = 4'h5; lsb = 4'h9;
    wr_n = 0; tick(3); wr_n = 1;
    wait_int(40);
    chk("R7 auto data drive", data, 8'h59);
    wr_n = 0; tick(4);
    chk("R7 write fall keeps int", int_no, 0);
    wr_n = 1; tick(4);
    chk("R7 write rise clears int", int_no, 1);
    wait_int(40);
    rd_n = 1; cs_n = 1; tick(4);

    // write-then-read, sample/hold
    restart(1, 1);
    addr = 2'b01; cs_n = 0; tick(4);
    chk("R3 select edge latches address", chan, 4'b0010);
    addr = 2'b10; msb = 4'hE; lsb = 4'h2;
    wr_n = 0; tick(3); wr_n = 1;
    wait_int(40);
    chk("R3 no relatch on write in sample/hold", chan, 4'b0010);
    wr_n = 0; tick(2); wr_n = 1; tick(15);
    chk("R8 start in gap ignored", int_no, 1);
    wr_n = 0; tick(3); wr_n = 1;
    wait_int(40);
    chk("R8 start after gap accepted", int_no, 0);
    tick(2);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule